// File: doc/BRIEF.md
# Branch and Next-PC Unit

This unit works out the address of the next instruction for a 32-bit RISC core whose instructions are all one word long. Each accepted instruction comes with its own PC and the two source register values read for it. The unit decides whether control flow changes and gives the address that fetch must use next. It covers six register-to-register compare-and-branch forms, a PC-relative jump, a jump through a register, and two call forms: one relative and one through a register. Calls also produce a write of the return address into the link register. A jump through either of two reserved register numbers is also reported to the interrupt controller, as an exception return or as a breakpoint return.

The unit sits in the pipeline as one registered stage with a valid/ready handshake on both sides. An instruction is taken in on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the output registers in the next cycle, with `out_valid` high. `in_ready` is high when the output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). A full rate of one instruction per cycle is therefore possible. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new input is taken in. The link-write, return and taken pins are plain qualifiers of the result and mean something only while `out_valid` is high.

Top module: `bnpc_unit`

## Requirements
- R1: The primary opcode is instruction bits [31:26], and bits [25:21] and [20:16] name sources A and B. Opcodes 0x11 (A==B), 0x17 (A!=B), 0x12 (signed A>B), 0x13 (signed A>=B), 0x15 (unsigned A>B) and 0x14 (unsigned A>=B) are conditional branches. When the condition holds, the next PC is PC plus bits [15:0] shifted left by two and sign-extended, and taken is 1.
- R2: A conditional branch whose condition fails gives next PC = PC+4 and taken = 0.
- R3: Opcodes 0x38 (jump) and 0x3E (call) are taken. Their next PC is PC plus bits [25:0] shifted left by two and sign-extended.
- R4: Both call forms (0x3E relative, 0x36 through a register) assert the link write with index 29 and link data PC+4. No other instruction asserts the link write.
- R5: Opcodes 0x30 (jump through a register) and 0x36 (call through a register) are taken and give next PC = source A.
- R6: Opcode 0x30 with register field 30 raises the exception-return flag, and with register field 31 raises the breakpoint-return flag. Every other instruction, including 0x36 through register 30 or 31, raises neither flag.
- R7: Any other opcode gives next PC = PC+4, taken = 0, no link write and no return flag.
- R8: An input is taken in only when in_ready is high, and in_ready = !out_valid || out_ready. The result appears with out_valid one cycle after it is taken in. While out_ready is low, the result stays unchanged.
- R9: During and after reset, out_valid is 0 and in_ready is 1.
- R10: The two low bits of every next PC are zero, including for a register target with those bits set.
- R11: The link data always equals the instruction's PC+4, so a result that is not taken has next PC equal to link data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit can take the instruction |
| in_pc | input | 32 | PC of the instruction |
| in_instr | input | 32 | Instruction word |
| in_src_a | input | 32 | Value of source register A |
| in_src_b | input | 32 | Value of source register B |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_next_pc | output | 32 | Address to fetch next |
| out_taken | output | 1 | Control flow changed |
| out_link_we | output | 1 | Write link data to link register |
| out_link_idx | output | 5 | Link register index (29) |
| out_link_data | output | 32 | PC+4 of the instruction |
| out_exc_ret | output | 1 | Exception return executed |
| out_brk_ret | output | 1 | Breakpoint return executed |

## Verification
The assertions check on every cycle that a stalled result stays unchanged, that every next PC is word-aligned, and that a link write only comes with a taken result. They also check that the two return flags are never both set and never appear on a call, and that an untaken result points to the link data. Only the bench's scenarios can show that each compare chooses the right direction for signed and unsigned operands, and that the branch offsets are sign-extended to the correct targets in both directions. The scenarios also show that register 30 and register 31 are recognised only on the plain register jump, and how the handshake behaves when a new instruction arrives during a stall.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;
  localparam int ILEN    = 32;
  localparam int OPC_W   = 6;
  localparam int RIDX_W  = 5;
  localparam int IMMS_W  = 16;
  localparam int IMML_W  = 26;
  localparam int OPC_LSB = 26;
  localparam int RA_LSB  = 21;

  localparam logic [OPC_W-1:0] OP_BEQ   = 6'h11;
  localparam logic [OPC_W-1:0] OP_BGT   = 6'h12;
  localparam logic [OPC_W-1:0] OP_BGE   = 6'h13;
  localparam logic [OPC_W-1:0] OP_BGEU  = 6'h14;
  localparam logic [OPC_W-1:0] OP_BGTU  = 6'h15;
  localparam logic [OPC_W-1:0] OP_BNE   = 6'h17;
  localparam logic [OPC_W-1:0] OP_JREG  = 6'h30;
  localparam logic [OPC_W-1:0] OP_CREG  = 6'h36;
  localparam logic [OPC_W-1:0] OP_JREL  = 6'h38;
  localparam logic [OPC_W-1:0] OP_CREL  = 6'h3E;

  typedef enum logic [1:0] {
    K_SEQ  = 2'd0,
    K_COND = 2'd1,
    K_REL  = 2'd2,
    K_REG  = 2'd3
  } flow_kind_e;

  typedef enum logic [2:0] {
    C_EQ  = 3'd0,
    C_NE  = 3'd1,
    C_GT  = 3'd2,
    C_GE  = 3'd3,
    C_GTU = 3'd4,
    C_GEU = 3'd5
  } cmp_op_e;
endpackage

// File: rtl/bnpc_decode.sv
module bnpc_decode
  import bnpc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int ERET_RG = 30,
  parameter int BRET_RG = 31
) (
  input  logic [ILEN-1:0] instr,
  output flow_kind_e      kind,
  output cmp_op_e         cmp,
  output logic            is_call,
  output logic            exc_ret,
  output logic            brk_ret,
  output logic [XLEN-1:0] off_short,
  output logic [XLEN-1:0] off_long
);
  localparam int SEXT_S = XLEN - IMMS_W - 2;
  localparam int SEXT_L = XLEN - IMML_W - 2;

  logic [OPC_W-1:0]  opc;
  logic [RIDX_W-1:0] rfield;
  logic [IMMS_W-1:0] imm_s;
  logic [IMML_W-1:0] imm_l;

  assign opc    = instr[OPC_LSB +: OPC_W];
  assign rfield = instr[RA_LSB +: RIDX_W];
  assign imm_s  = instr[IMMS_W-1:0];
  assign imm_l  = instr[IMML_W-1:0];

  assign off_short = {{SEXT_S{imm_s[IMMS_W-1]}}, imm_s, 2'b00};
  assign off_long  = {{SEXT_L{imm_l[IMML_W-1]}}, imm_l, 2'b00};

  always_comb begin
    kind    = K_SEQ;
    cmp     = C_EQ;
    is_call = 1'b0;
    unique case (opc)
      OP_BEQ:  begin kind = K_COND; cmp = C_EQ;  end
      OP_BNE:  begin kind = K_COND; cmp = C_NE;  end
      OP_BGT:  begin kind = K_COND; cmp = C_GT;  end
      OP_BGE:  begin kind = K_COND; cmp = C_GE;  end
      OP_BGTU: begin kind = K_COND; cmp = C_GTU; end
      OP_BGEU: begin kind = K_COND; cmp = C_GEU; end
      OP_JREL: kind = K_REL;
      OP_CREL: begin kind = K_REL; is_call = 1'b1; end
      OP_JREG: kind = K_REG;
      OP_CREG: begin kind = K_REG; is_call = 1'b1; end
      default: kind = K_SEQ;
    endcase
  end

  // Only the plain register jump doubles as a return
  assign exc_ret = (opc == OP_JREG) && (rfield == RIDX_W'(ERET_RG));
  assign brk_ret = (opc == OP_JREG) && (rfield == RIDX_W'(BRET_RG));
endmodule

// File: rtl/bnpc_compare.sv
module bnpc_compare
  import bnpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  cmp_op_e         cmp,
  output logic            hit
);
  logic eq, gt_u, gt_s;

  assign eq   = (src_a == src_b);
  assign gt_u = (src_a > src_b);
  assign gt_s = ($signed(src_a) > $signed(src_b));

  always_comb begin
    unique case (cmp)
      C_EQ:    hit = eq;
      C_NE:    hit = !eq;
      C_GT:    hit = gt_s;
      C_GE:    hit = gt_s || eq;
      C_GTU:   hit = gt_u;
      C_GEU:   hit = gt_u || eq;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bnpc_target.sv
module bnpc_target
  import bnpc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int ALIGN = 2
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] src_a,
  input  flow_kind_e      kind,
  input  logic            hit,
  input  logic [XLEN-1:0] off_short,
  input  logic [XLEN-1:0] off_long,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] next_pc,
  output logic            taken
);
  localparam logic [XLEN-1:0] STEP = XLEN'(1) << ALIGN;
  localparam logic [XLEN-1:0] MASK = ~((XLEN'(1) << ALIGN) - XLEN'(1));

  logic [XLEN-1:0] raw;

  assign seq_pc = (pc + STEP) & MASK;

  always_comb begin
    taken = 1'b0;
    raw   = seq_pc;
    unique case (kind)
      K_COND: begin
        taken = hit;
        raw   = hit ? (pc + off_short) : seq_pc;
      end
      K_REL: begin
        taken = 1'b1;
        raw   = pc + off_long;
      end
      K_REG: begin
        taken = 1'b1;
        raw   = src_a;
      end
      default: begin
        taken = 1'b0;
        raw   = seq_pc;
      end
    endcase
  end

  assign next_pc = raw & MASK;
endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
  import bnpc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int LINK_RG = 29,
  parameter int ERET_RG = 30,
  parameter int BRET_RG = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [XLEN-1:0]   in_pc,
  input  logic [ILEN-1:0]   in_instr,
  input  logic [XLEN-1:0]   in_src_a,
  input  logic [XLEN-1:0]   in_src_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XLEN-1:0]   out_next_pc,
  output logic              out_taken,
  output logic              out_link_we,
  output logic [RIDX_W-1:0] out_link_idx,
  output logic [XLEN-1:0]   out_link_data,
  output logic              out_exc_ret,
  output logic              out_brk_ret
);
  flow_kind_e      kind;
  cmp_op_e         cmp;
  logic            is_call, exc_ret, brk_ret, hit, taken;
  logic [XLEN-1:0] off_short, off_long, seq_pc, next_pc;

  bnpc_decode #(.XLEN(XLEN), .ERET_RG(ERET_RG), .BRET_RG(BRET_RG)) u_dec (
    .instr(in_instr), .kind(kind), .cmp(cmp), .is_call(is_call),
    .exc_ret(exc_ret), .brk_ret(brk_ret),
    .off_short(off_short), .off_long(off_long)
  );

  bnpc_compare #(.XLEN(XLEN)) u_cmp (
    .src_a(in_src_a), .src_b(in_src_b), .cmp(cmp), .hit(hit)
  );

  bnpc_target #(.XLEN(XLEN)) u_tgt (
    .pc(in_pc), .src_a(in_src_a), .kind(kind), .hit(hit),
    .off_short(off_short), .off_long(off_long),
    .seq_pc(seq_pc), .next_pc(next_pc), .taken(taken)
  );

  assign in_ready     = !out_valid || out_ready;
  assign out_link_idx = RIDX_W'(LINK_RG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_next_pc   <= '0;
      out_taken     <= 1'b0;
      out_link_we   <= 1'b0;
      out_link_data <= '0;
      out_exc_ret   <= 1'b0;
      out_brk_ret   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_next_pc   <= next_pc;
        out_taken     <= taken;
        out_link_we   <= is_call;
        out_link_data <= seq_pc;
        out_exc_ret   <= exc_ret;
        out_brk_ret   <= brk_ret;
      end
    end
  end

  // R8: a stalled result is held unchanged
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_next_pc)
      && $stable(out_taken) && $stable(out_link_we) && $stable(out_link_data))
    else $error("stalled result changed");

  // R10: every next PC is word aligned
  p_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_next_pc[1:0] == 2'b00)
    else $error("unaligned next pc");

  // R4: a link write only comes with a taken result
  p_link_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_link_we |-> out_taken)
    else $error("link write without taken");

  // R6: return flags are exclusive and never on a call
  p_ret_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_exc_ret || out_brk_ret) |->
      $onehot0({out_exc_ret, out_brk_ret}) && out_taken && !out_link_we)
    else $error("bad return flags");

  // R11: an untaken result falls through to the link data
  p_fallthru_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_taken |-> out_next_pc == out_link_data)
    else $error("fall-through mismatch");
endmodule

// File: tb/sim_bnpc_unit.sv
`timescale 1ns/1ps
module sim_bnpc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pc = '0, in_instr = '0, in_src_a = '0, in_src_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_next_pc, out_link_data;
  logic        out_taken, out_link_we, out_exc_ret, out_brk_ret;
  logic [4:0]  out_link_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bnpc_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_instr(in_instr), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_next_pc(out_next_pc),
    .out_taken(out_taken), .out_link_we(out_link_we), .out_link_idx(out_link_idx),
    .out_link_data(out_link_data), .out_exc_ret(out_exc_ret), .out_brk_ret(out_brk_ret)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] ins;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] nxt;
    logic        tk;
    logic        lk;
    logic        er;
    logic        br;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{32'h1000, 32'h44220010, 32'd5,        32'd5,        32'h1040, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h1000, 32'h44220010, 32'd5,        32'd6,        32'h1004, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h1000, 32'h5C22FFFF, 32'd1,        32'd2,        32'h0FFC, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h1000, 32'h48220008, 32'hFFFFFFFF, 32'd1,        32'h1004, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h1000, 32'h48220008, 32'd1,        32'hFFFFFFFF, 32'h1020, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h1000, 32'h54220008, 32'hFFFFFFFF, 32'd1,        32'h1020, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h1000, 32'h4C220008, 32'd7,        32'd7,        32'h1020, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h1000, 32'h50220008, 32'd1,        32'd2,        32'h1004, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h2000, 32'hE0000100, 32'd0,        32'd0,        32'h2400, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h2000, 32'hE3FFFFFE, 32'd0,        32'd0,        32'h1FF8, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h3000, 32'hF8000010, 32'd0,        32'd0,        32'h3040, 1'b1, 1'b1, 1'b0, 1'b0},
    '{32'h3000, 32'hC0A00000, 32'h4003,     32'd0,        32'h4000, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h3000, 32'hC3C00000, 32'h5000,     32'd0,        32'h5000, 1'b1, 1'b0, 1'b1, 1'b0},
    '{32'h3000, 32'hC3E00000, 32'h6000,     32'd0,        32'h6000, 1'b1, 1'b0, 1'b0, 1'b1},
    '{32'h3000, 32'hD8600000, 32'h7000,     32'd0,        32'h7000, 1'b1, 1'b1, 1'b0, 1'b0},
    '{32'h3000, 32'hDBC00000, 32'h8000,     32'd0,        32'h8000, 1'b1, 1'b1, 1'b0, 1'b0},
    '{32'h1000, 32'h34220000, 32'd9,        32'd9,        32'h1004, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h1000, 32'h58220010, 32'd9,        32'd9,        32'h1004, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  function automatic string tag_of(input logic [31:0] ins);
    case (ins[31:26])
      6'h11, 6'h12, 6'h13, 6'h14, 6'h15, 6'h17: return "R1/R2";
      6'h38: return "R3";
      6'h3E: return "R3/R4";
      6'h30: return "R5/R6";
      6'h36: return "R4/R5/R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] pc, input logic [31:0] ins,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_pc = pc; in_instr = ins; in_src_a = a; in_src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(out_valid == 1'b0, "R9", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk(in_ready == 1'b1, "R9", "in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid after reset", {31'd0, out_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].pc, VEC[i].ins, VEC[i].a, VEC[i].b);
      chk(out_valid == 1'b1, "R8", "result valid", {31'd0, out_valid}, 32'd1);
      chk(out_next_pc == VEC[i].nxt, tag_of(VEC[i].ins), "next pc", out_next_pc, VEC[i].nxt);
      chk(out_taken == VEC[i].tk, tag_of(VEC[i].ins), "taken", {31'd0, out_taken}, {31'd0, VEC[i].tk});
      chk(out_link_we == VEC[i].lk, "R4", "link write", {31'd0, out_link_we}, {31'd0, VEC[i].lk});
      chk(out_exc_ret == VEC[i].er && out_brk_ret == VEC[i].br, "R6", "return flags",
          {30'd0, out_exc_ret, out_brk_ret}, {30'd0, VEC[i].er, VEC[i].br});
      chk(out_link_data == VEC[i].pc + 32'd4, "R11", "link data", out_link_data, VEC[i].pc + 32'd4);
      chk(out_next_pc[1:0] == 2'b00, "R10", "alignment", out_next_pc, VEC[i].nxt);
      if (VEC[i].lk)
        chk(out_link_idx == 5'd29, "R4", "link index", {27'd0, out_link_idx}, 32'd29);
    end

    // R8: stall holds result and blocks new input
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_pc = 32'h3000; in_instr = 32'hF8000010; in_src_a = 0; in_src_b = 0;
    @(negedge clk);
    in_pc = 32'h1000; in_instr = 32'h34220000;
    chk(in_ready == 1'b0, "R8", "in_ready low in stall", {31'd0, in_ready}, 32'd0);
    chk(out_next_pc == 32'h3040, "R8", "first result", out_next_pc, 32'h3040);
    @(negedge clk);
    @(negedge clk);
    chk(out_valid && out_next_pc == 32'h3040 && out_link_we, "R8", "held during stall",
        out_next_pc, 32'h3040);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_next_pc == 32'h1004 && !out_link_we, "R8", "second after release",
        out_next_pc, 32'h1004);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", "drained", {31'd0, out_valid}, 32'd0);

    // R8: back-to-back acceptance at full rate
    in_valid = 1'b1; in_pc = 32'h2000; in_instr = 32'hE0000100;
    @(negedge clk);
    chk(out_next_pc == 32'h2400 && in_ready, "R8", "back-to-back first", out_next_pc, 32'h2400);
    in_instr = 32'hE3FFFFFE;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_next_pc == 32'h1FF8, "R3", "back-to-back second", out_next_pc, 32'h1FF8);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule